// File: doc/BRIEF.md
# Inbound Link Fault Latch and Response Selector

This block sits after the decoder of a serial link receiver and sees one decoded event per cycle. When the receiver reports a failure (signal lost or word sync lost), or when the far end starts sending one of four continuous sequences, the block shuts the inbound path. It records why, raises a host interrupt and selects the continuous sequence the transmitter must send back. The link stays shut, and every later inbound event is thrown away, until the host writes a re-enable. One interrupt is raised per shutdown, and nothing else interrupts the host until it recovers the link.

The host can also arm a one-shot interrupt that fires when a valid-sequence marker arrives on an open link. This lets recovery code find out when the far end has come back. The arm bit clears itself when the interrupt fires. Isolated bit errors inside idle words are harmless and never shut the link.

Top module: `lnk_fault_filter`

## Requirements
- R1: After a synchronous active-high reset, the link is open, the cause is 0, `ob_sel` is 0, `irq` is 0 and the status word reads 0.
- R2: An accepted event with code 2 (signal lost) or 3 (sync lost) shuts the link at the clock edge that samples it and stores cause 1 or 2.
- R3: An accepted event with code 4, 5, 6 or 7 (continuous sequence types A to D) shuts the link at the sampling edge and stores cause 3, 4, 5 or 6.
- R4: Event codes 0 (idle), 1 (idle with a single-bit error) and 9 to 15 (ordinary words) never shut the link and never change the cause or `ob_sel`.
- R5: While the link is shut, every inbound event is dropped. The cause and `ob_sel` hold, and a valid-sequence marker cannot fire the armed interrupt.
- R6: `ob_sel` is 0 while the link is open. From the shutting edge it is 1 for cause 1, 2 for cause 2, 4 for type A, 3 for type B and 6 for types C and D. It holds that value until re-enable.
- R7: `irq` is high whenever the link is shut or the valid-sequence flag is set. Status (address 0) packs bit 0 link shut, bits 3:1 cause, bit 4 valid-sequence flag and bit 5 arm. `host_rdata` presents the word at the address sampled on the previous edge, and other addresses read 0.
- R8: A host write to address 1 with bit 0 set re-opens a shut link and clears the cause and `ob_sel` to 0. On an open link it has no effect, so a failure event in the same cycle still shuts the link.
- R9: A write to address 1 with bit 1 set arms the valid-sequence interrupt. An accepted event with code 8 on an armed, open link sets the flag and clears the arm bit. Code 8 while unarmed does nothing. If firing and arming fall in the same cycle, firing wins.
- R10: A write to address 1 with bit 2 set clears the valid-sequence flag. A firing in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Decoded inbound event present |
| ev_code | input | EV_W | Decoded event code |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HADDR_W | Host register address |
| host_wdata | input | HDATA_W | Host write data |
| host_rdata | output | HDATA_W | Registered host read data |
| irq | output | 1 | Host interrupt, level |
| ob_sel | output | 3 | Outbound continuous-sequence select |

## Verification
A wrong shut flag shows at once. `irq` and `ob_sel` disagree with the last accepted trigger one edge after it, and the status word shows it on the edge after that. A corrupted cause shows up as a wrong outbound response in the same cycle, so a missing drop of events while shut becomes visible as soon as a second trigger would have overwritten the cause. A stuck arm bit is only exposed by the next valid-sequence marker, and the bench spaces those out to catch it.

// File: rtl/lff_pkg.sv
package lff_pkg;

  localparam int CAUSE_W = 3;
  localparam int OB_W    = 3;

  // decoded inbound event codes
  localparam int EVC_IDLE     = 0;
  localparam int EVC_IDLE_ERR = 1;
  localparam int EVC_SIG_LOST = 2;
  localparam int EVC_SYNC_LOST = 3;
  localparam int EVC_SEQ_A    = 4;
  localparam int EVC_SEQ_D    = 7;
  localparam int EVC_VSEQ     = 8;

  // stored cause values
  localparam logic [CAUSE_W-1:0] CZ_NONE  = 3'd0;
  localparam logic [CAUSE_W-1:0] CZ_SIG   = 3'd1;
  localparam logic [CAUSE_W-1:0] CZ_SYNC  = 3'd2;
  localparam logic [CAUSE_W-1:0] CZ_SEQ_A = 3'd3;
  localparam logic [CAUSE_W-1:0] CZ_SEQ_B = 3'd4;
  localparam logic [CAUSE_W-1:0] CZ_SEQ_C = 3'd5;
  localparam logic [CAUSE_W-1:0] CZ_SEQ_D = 3'd6;

  // outbound continuous-sequence selections
  localparam logic [OB_W-1:0] OBS_IDLE    = 3'd0;
  localparam logic [OB_W-1:0] OBS_SIG     = 3'd1;
  localparam logic [OB_W-1:0] OBS_SYNC    = 3'd2;
  localparam logic [OB_W-1:0] OBS_RSP_B   = 3'd3;
  localparam logic [OB_W-1:0] OBS_RSP_A   = 3'd4;
  localparam logic [OB_W-1:0] OBS_RSP_CD  = 3'd6;

  typedef struct packed {
    logic                 trip;
    logic                 vseq;
    logic [CAUSE_W-1:0]   cause;
  } lff_class_t;

  function automatic logic [OB_W-1:0] resp_for(input logic [CAUSE_W-1:0] cz);
    case (cz)
      CZ_SIG:   resp_for = OBS_SIG;
      CZ_SYNC:  resp_for = OBS_SYNC;
      CZ_SEQ_A: resp_for = OBS_RSP_A;
      CZ_SEQ_B: resp_for = OBS_RSP_B;
      CZ_SEQ_C: resp_for = OBS_RSP_CD;
      CZ_SEQ_D: resp_for = OBS_RSP_CD;
      default:  resp_for = OBS_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/lff_classify.sv
module lff_classify
  import lff_pkg::*;
#(
  parameter int EV_W = 4
) (
  input  logic            ev_take,
  input  logic [EV_W-1:0] ev_code,
  output lff_class_t      cls
);

  always_comb begin
    cls = '0;
    if (ev_take) begin
      if (ev_code == EV_W'(EVC_SIG_LOST)) begin
        cls.trip  = 1'b1;
        cls.cause = CZ_SIG;
      end else if (ev_code == EV_W'(EVC_SYNC_LOST)) begin
        cls.trip  = 1'b1;
        cls.cause = CZ_SYNC;
      end else if (ev_code >= EV_W'(EVC_SEQ_A) && ev_code <= EV_W'(EVC_SEQ_D)) begin
        cls.trip  = 1'b1;
        cls.cause = CZ_SEQ_A + CAUSE_W'(ev_code - EV_W'(EVC_SEQ_A));
      end else if (ev_code == EV_W'(EVC_VSEQ)) begin
        cls.vseq  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lff_link_state.sv
module lff_link_state
  import lff_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  lff_class_t         cls,
  input  logic               reopen,
  output logic               link_off,
  output logic [CAUSE_W-1:0] cause_q,
  output logic [OB_W-1:0]    ob_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_off <= 1'b0;
      cause_q  <= CZ_NONE;
      ob_q     <= OBS_IDLE;
    end else if (cls.trip) begin
      link_off <= 1'b1;
      cause_q  <= cls.cause;
      ob_q     <= resp_for(cls.cause);
    end else if (reopen && link_off) begin
      link_off <= 1'b0;
      cause_q  <= CZ_NONE;
      ob_q     <= OBS_IDLE;
    end
  end

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    link_off && !reopen |=> link_off);                                 // R5
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (rst)
    link_off && !reopen |=> $stable(cause_q) && $stable(ob_q));        // R5
  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(link_off) |-> cause_q != CZ_NONE && ob_q != OBS_IDLE);       // R6

endmodule

// File: rtl/lff_host_regs.sv
module lff_host_regs
  import lff_pkg::*;
#(
  parameter int HADDR_W = 2,
  parameter int HDATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  input  logic               link_off,
  input  logic [CAUSE_W-1:0] cause_q,
  input  logic               vseq_hit,
  output logic               reopen,
  output logic               vs_flag,
  output logic [HDATA_W-1:0] host_rdata
);

  localparam int STAT_W = CAUSE_W + 3;
  localparam logic [HADDR_W-1:0] A_STAT = HADDR_W'(0);
  localparam logic [HADDR_W-1:0] A_CTRL = HADDR_W'(1);

  logic armed;
  logic ctrl_wr;
  logic fire;
  logic [STAT_W-1:0] stat_word;

  assign ctrl_wr = host_wr && (host_addr == A_CTRL);
  assign reopen  = ctrl_wr && host_wdata[0];
  assign fire    = vseq_hit && armed && !link_off;
  assign stat_word = {armed, vs_flag, cause_q, link_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      vs_flag <= 1'b0;
    end else begin
      if (fire)                          armed <= 1'b0;
      else if (ctrl_wr && host_wdata[1]) armed <= 1'b1;
      if (fire)                          vs_flag <= 1'b1;
      else if (ctrl_wr && host_wdata[2]) vs_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     host_rdata <= '0;
    else if (host_addr == A_STAT) host_rdata <= HDATA_W'(stat_word);
    else                         host_rdata <= '0;
  end

  AST_ARM_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_flag) |-> !armed);                                        // R9
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    link_off |=> !$rose(vs_flag));                                     // R5

endmodule

// File: rtl/lnk_fault_filter.sv
module lnk_fault_filter
  import lff_pkg::*;
#(
  parameter int EV_W    = 4,
  parameter int HADDR_W = 2,
  parameter int HDATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic [EV_W-1:0]    ev_code,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [HDATA_W-1:0] host_wdata,
  output logic [HDATA_W-1:0] host_rdata,
  output logic               irq,
  output logic [2:0]         ob_sel
);

  logic               link_off;
  logic               ev_take;
  logic               reopen;
  logic               vs_flag;
  logic [CAUSE_W-1:0] cause_q;
  logic [OB_W-1:0]    ob_q;
  lff_class_t         cls;

  assign ev_take = ev_valid && !link_off;

  lff_classify #(.EV_W(EV_W)) u_classify (
    .ev_take (ev_take),
    .ev_code (ev_code),
    .cls     (cls)
  );

  lff_link_state u_state (
    .clk      (clk),
    .rst      (rst),
    .cls      (cls),
    .reopen   (reopen),
    .link_off (link_off),
    .cause_q  (cause_q),
    .ob_q     (ob_q)
  );

  lff_host_regs #(.HADDR_W(HADDR_W), .HDATA_W(HDATA_W)) u_host (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .link_off   (link_off),
    .cause_q    (cause_q),
    .vseq_hit   (cls.vseq),
    .reopen     (reopen),
    .vs_flag    (vs_flag),
    .host_rdata (host_rdata)
  );

  assign irq    = link_off | vs_flag;
  assign ob_sel = ob_q;

  AST_BITERR_HARMLESS: assert property (@(posedge clk) disable iff (rst)
    ev_valid && !link_off && ev_code == EV_W'(EVC_IDLE_ERR) |=> !link_off); // R4
  AST_OPEN_QUIET_OB: assert property (@(posedge clk) disable iff (rst)
    !link_off |-> ob_sel == OBS_IDLE);                                     // R6
  AST_IRQ_ON_TRIP: assert property (@(posedge clk) disable iff (rst)
    ev_take && cls.trip |=> irq);                                          // R7

endmodule

// File: tb/lnk_fault_filter_bench.sv
module lnk_fault_filter_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       ev_valid;
  logic [3:0] ev_code;
  logic       host_wr;
  logic [1:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       irq;
  logic [2:0] ob_sel;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // reference state, derived from the requirements
  bit       m_off, m_vs, m_arm;
  bit [2:0] m_cause, m_ob;
  bit [7:0] m_rd;

  always #10 clk = ~clk;

  lnk_fault_filter u_lnk_fault_filter (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq), .ob_sel(ob_sel)
  );

  function automatic bit [2:0] exp_cause(input bit [3:0] c);
    if (c == 2) return 3'd1;
    if (c == 3) return 3'd2;
    if (c >= 4 && c <= 7) return 3'(c - 1);
    return 3'd0;
  endfunction

  function automatic bit [2:0] exp_resp(input bit [2:0] cz);
    case (cz)
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd3: return 3'd4;
      3'd4: return 3'd3;
      3'd5, 3'd6: return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(ob_sel, m_ob, "R6");
    chk(irq, m_off | m_vs, "R7");
    chk(host_rdata, m_rd, "R7");
    chk(host_rdata == 8'h00 ? 0 : 1, m_rd == 8'h00 ? 0 : 1, "R5");
  endtask

  // apply one cycle of stimulus at a falling edge, advance the model, compare
  task automatic step(input bit v, input bit [3:0] c, input bit we,
                      input bit [1:0] a, input bit [7:0] wd);
    bit acc, nd, nv, na;
    bit [2:0] nc, no;
    ev_valid = v; ev_code = c; host_wr = we; host_addr = a; host_wdata = wd;
    acc = v && !m_off;
    nd = m_off; nv = m_vs; na = m_arm; nc = m_cause; no = m_ob;
    if (we && a == 1 && wd[0] && m_off) begin nd = 0; nc = 0; no = 0; end
    if (acc && exp_cause(c) != 0) begin
      nd = 1; nc = exp_cause(c); no = exp_resp(exp_cause(c));
    end
    if (we && a == 1 && wd[1]) na = 1;
    if (we && a == 1 && wd[2]) nv = 0;
    if (acc && c == 8 && m_arm) begin nv = 1; na = 0; end
    m_rd = (a == 0) ? {2'b00, m_arm, m_vs, m_cause, m_off} : 8'h00;
    @(posedge clk);
    @(negedge clk);
    m_off = nd; m_vs = nv; m_arm = na; m_cause = nc; m_ob = no;
    compare_all();
  endtask

  task automatic ev(input bit [3:0] c);
    step(1'b1, c, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wctl(input bit [7:0] wd);
    step(1'b0, 4'd0, 1'b1, 2'd1, wd);
  endtask

  task automatic rd_status();
    step(1'b0, 4'd0, 1'b0, 2'd0, 8'h00);
    step(1'b0, 4'd0, 1'b0, 2'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    rst = 1'b1; ev_valid = 0; ev_code = 0; host_wr = 0; host_addr = 0; host_wdata = 0;
    m_off = 0; m_vs = 0; m_arm = 0; m_cause = 0; m_ob = 0; m_rd = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(irq, 0, "R1");
    chk(ob_sel, 0, "R1");
    chk(host_rdata, 0, "R1");
    rd_status();
    chk(host_rdata, 0, "R1");

    // R4: harmless codes
    ev(4'd0); ev(4'd1); ev(4'd1); ev(4'd9); ev(4'd15);
    rd_status();
    chk(host_rdata[0], 0, "R4");
    chk(ob_sel, 0, "R4");

    // R2: signal lost, then R5: later trigger dropped
    ev(4'd2);
    chk(ob_sel, 1, "R2");
    chk(irq, 1, "R2");
    ev(4'd4); ev(4'd3);
    rd_status();
    chk(host_rdata, 8'h03, "R5");
    chk(ob_sel, 1, "R5");
    wctl(8'h01);
    chk(ob_sel, 0, "R8");
    chk(irq, 0, "R8");

    // R2: sync lost
    ev(4'd3);
    rd_status();
    chk(host_rdata, 8'h05, "R2");
    chk(ob_sel, 2, "R6");
    wctl(8'h01);

    // R3 and R6: each continuous sequence type
    for (int k = 0; k < 4; k++) begin
      ev(4'(4 + k));
      rd_status();
      chk(host_rdata[3:1], 3 + k, "R3");
      chk(ob_sel, exp_resp(3'(3 + k)), "R6");
      wctl(8'h01);
    end

    // R8: re-enable while open does nothing; failure in the same cycle wins
    wctl(8'h01);
    chk(irq, 0, "R8");
    step(1'b1, 4'd2, 1'b1, 2'd1, 8'h01);
    chk(ob_sel, 1, "R8");
    chk(irq, 1, "R8");
    wctl(8'h01);

    // R9: arm, fire, self-clear
    ev(4'd8);
    chk(irq, 0, "R9");
    wctl(8'h02);
    rd_status();
    chk(host_rdata, 8'h20, "R9");
    ev(4'd8);
    chk(irq, 1, "R9");
    rd_status();
    chk(host_rdata, 8'h10, "R9");
    // R10: clear the flag
    wctl(8'h04);
    chk(irq, 0, "R10");
    ev(4'd8);
    chk(irq, 0, "R9");

    // R5: armed marker while shut does not fire
    wctl(8'h02);
    ev(4'd5);
    ev(4'd8);
    wctl(8'h01);
    rd_status();
    chk(host_rdata, 8'h20, "R5");
    wctl(8'h00);

    // random traffic with occasional host writes
    for (int i = 0; i < 3000; i++) begin
      bit v, we;
      bit [3:0] c;
      bit [1:0] a;
      bit [7:0] wd;
      int r;
      v = ($urandom_range(0, 3) != 0);
      r = $urandom_range(0, 99);
      if (r < 40)      c = 4'($urandom_range(0, 1));
      else if (r < 60) c = 4'($urandom_range(9, 15));
      else if (r < 80) c = 4'd8;
      else             c = 4'($urandom_range(2, 7));
      we = ($urandom_range(0, 4) == 0);
      a  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) a = 2'd1;
      wd = 8'($urandom_range(0, 255));
      step(v, c, we, a, wd);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule